// File: doc/BRIEF.md
# Host command stream parser

This block sits behind a channel FIFO and turns a stream of 32-bit command words into register-write strobes and side-band requests. Each word taken while no payload is outstanding is a header; its top nibble selects the command, and the command fixes how many payload words come next. Each payload word becomes one register write that carries the current class, an offset and the word itself. The exception is a gather, whose single payload word is the memory address for a gather request.

Restart headers produce a new fetch address. Extend headers produce module-lock acquire or release requests. Unknown extend sub-codes raise an error pulse. The block keeps the active class, the running offset, the outstanding payload count and, for the two masked forms, the mask bits that are still unused. Fetching gather memory, arbitrating locks and holding the target registers are left to neighbouring blocks.

Top module: `cmd_stream_parser`

## Requirements
- R1: After reset all strobes are low, `cur_class` is 0, `in_payload` is low and `in_ready` is high; one word is accepted on every cycle in which `in_valid` is high.
- R2: A header's opcode is bits 31:28, coded 0 set-class, 1 incrementing write, 2 non-incrementing write, 3 masked write, 4 immediate, 5 restart, 6 gather, 14 extend; every other code is a header with no payload and no strobe.
- R3: Set-class loads the class from bits 15:6. A non-zero 6-bit mask in bits 5:0 is followed by popcount(mask) payload words. The nth of these is written, with the new class, to offset bits 27:16 plus the position of the nth set mask bit counted from bit 0. A zero mask only changes the class.
- R4: An incrementing write takes its offset from bits 27:16 and its word count from bits 15:0. Payload word k goes to offset+k, taken modulo 4096, and a count of 0 means no payload.
- R5: A non-incrementing write takes the same fields as R4 but sends every payload word to the header offset.
- R6: A masked write takes its offset from bits 27:16 and a 16-bit mask from bits 15:0. It is followed by popcount(mask) payload words, which are placed as in R3.
- R7: An immediate header gives one write strobe with data equal to bits 15:0 zero-extended, at offset bits 27:16, with the current class, and has no payload.
- R8: A gather header is followed by exactly one address word. That word gives one gather request carrying offset bits 27:16, insert bit 15, type bit 14, count bits 13:0 and the address word.
- R9: A restart header gives one restart request whose address is the header shifted left by 4 bits.
- R10: An extend header reads a sub-code from bits 27:24. Code 0 requests lock acquire and code 1 requests lock release, each with index bits 7:0. Any other code gives a one-cycle `ext_err` pulse.
- R11: Payload words are never decoded as headers, whatever their top nibble holds.
- R12: Every strobe is one cycle wide and appears in the cycle after its word is accepted, and at most one strobe is high per cycle. A cycle with `in_valid` low produces no strobe and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word valid |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Word accepted when high with in_valid |
| wr_valid | output | 1 | Register-write strobe |
| wr_class | output | 10 | Class of the write |
| wr_offset | output | 12 | Register offset of the write |
| wr_data | output | 32 | Write data |
| gather_valid | output | 1 | Gather request strobe |
| gather_offset | output | 12 | Gather target offset |
| gather_insert | output | 1 | Gather insert flag |
| gather_type | output | 1 | Gather type flag |
| gather_count | output | 14 | Gather word count |
| gather_addr | output | 32 | Gather memory address |
| restart_valid | output | 1 | Restart request strobe |
| restart_addr | output | 32 | New fetch address |
| lock_acq_valid | output | 1 | Lock acquire request |
| lock_rel_valid | output | 1 | Lock release request |
| lock_index | output | 8 | Lock index |
| ext_err | output | 1 | Unknown extend sub-code pulse |
| cur_class | output | 10 | Active class |
| in_payload | output | 1 | High while payload words are outstanding |

## Verification
A wrong payload count shows up as a framing slip. Either a payload word is read as a header, so a spurious restart, lock or error pulse appears, or a header is written out as data. In both cases `in_payload` disagrees with the model one cycle after the word that caused the error. A wrong mask or offset state shows on `wr_offset` at the very next payload word. A stale class shows on `wr_class` at the first write after a set-class. Random streams with random top nibbles in payload words make these slips appear within a few commands.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
  localparam int WORD_W     = 32;
  localparam int OP_W       = 4;
  localparam int CLASS_W    = 10;
  localparam int OFF_W      = 12;
  localparam int CNT_W      = 16;
  localparam int MASK_W     = 16;
  localparam int SCMASK_W   = 6;
  localparam int GCNT_W     = 14;
  localparam int LOCK_W     = 8;
  localparam int IMM_W      = 16;
  localparam int RESTART_SH = 4;
  localparam int POS_W      = $clog2(MASK_W);

  typedef enum logic [OP_W-1:0] {
    OP_SETCLASS = 4'd0,
    OP_INCR     = 4'd1,
    OP_NONINCR  = 4'd2,
    OP_MASKWR   = 4'd3,
    OP_IMM      = 4'd4,
    OP_RESTART  = 4'd5,
    OP_GATHER   = 4'd6,
    OP_EXTEND   = 4'd14
  } op_e;

  localparam logic [3:0] SUB_ACQ = 4'd0;
  localparam logic [3:0] SUB_REL = 4'd1;

  // how payload words of the current command are consumed
  typedef enum logic [1:0] {
    PM_STEP    = 2'd0,
    PM_HOLD    = 2'd1,
    PM_SCATTER = 2'd2,
    PM_ADDR    = 2'd3
  } pmode_e;

  typedef struct packed {
    logic [CNT_W-1:0]   n_payload;
    pmode_e             mode;
    logic [OFF_W-1:0]   base;
    logic [MASK_W-1:0]  mask;
    logic               class_we;
    logic [CLASS_W-1:0] class_val;
    logic               imm_we;
    logic [IMM_W-1:0]   imm_data;
    logic               restart;
    logic [WORD_W-1:0]  restart_addr;
    logic               acq;
    logic               rel;
    logic               unk;
    logic [LOCK_W-1:0]  lock_idx;
    logic               g_insert;
    logic               g_type;
    logic [GCNT_W-1:0]  g_count;
  } hdr_t;

  function automatic logic [CNT_W-1:0] mask_weight(input logic [MASK_W-1:0] m);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < MASK_W; i++) n = n + CNT_W'(m[i]);
    return n;
  endfunction

  function automatic logic [OFF_W-1:0] off_add(input logic [OFF_W-1:0] a,
                                               input logic [POS_W-1:0] p);
    return a + OFF_W'(p);
  endfunction
endpackage

// File: rtl/cmdp_hdr_decode.sv
module cmdp_hdr_decode
  import cmdp_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output hdr_t              hdr
);
  logic [OP_W-1:0]  op;
  logic [3:0]       sub;
  logic [OFF_W-1:0] off_f;

  assign op    = word[31:28];
  assign sub   = word[27:24];
  assign off_f = word[27:16];

  always_comb begin
    hdr = '0;
    hdr.mode = PM_STEP;
    case (op)
      OP_SETCLASS: begin
        hdr.class_we  = 1'b1;
        hdr.class_val = word[15:6];
        hdr.mask      = MASK_W'(word[SCMASK_W-1:0]);
        hdr.n_payload = mask_weight(MASK_W'(word[SCMASK_W-1:0]));
        hdr.base      = off_f;
        hdr.mode      = PM_SCATTER;
      end
      OP_INCR: begin
        hdr.base      = off_f;
        hdr.n_payload = word[15:0];
        hdr.mode      = PM_STEP;
      end
      OP_NONINCR: begin
        hdr.base      = off_f;
        hdr.n_payload = word[15:0];
        hdr.mode      = PM_HOLD;
      end
      OP_MASKWR: begin
        hdr.base      = off_f;
        hdr.mask      = word[15:0];
        hdr.n_payload = mask_weight(word[15:0]);
        hdr.mode      = PM_SCATTER;
      end
      OP_IMM: begin
        hdr.base     = off_f;
        hdr.imm_we   = 1'b1;
        hdr.imm_data = word[15:0];
      end
      OP_RESTART: begin
        hdr.restart      = 1'b1;
        hdr.restart_addr = word << RESTART_SH;
      end
      OP_GATHER: begin
        hdr.base      = off_f;
        hdr.g_insert  = word[15];
        hdr.g_type    = word[14];
        hdr.g_count   = word[13:0];
        hdr.n_payload = CNT_W'(1);
        hdr.mode      = PM_ADDR;
      end
      OP_EXTEND: begin
        hdr.lock_idx = word[7:0];
        hdr.acq      = (sub == SUB_ACQ);
        hdr.rel      = (sub == SUB_REL);
        hdr.unk      = (sub != SUB_ACQ) && (sub != SUB_REL);
      end
      default: hdr.n_payload = '0;
    endcase
  end
endmodule

// File: rtl/cmdp_mask_pick.sv
module cmdp_mask_pick
  import cmdp_pkg::*;
(
  input  logic [MASK_W-1:0] mask,
  output logic [POS_W-1:0]  pos,
  output logic [MASK_W-1:0] rest
);
  logic [MASK_W-1:0] first;

  // isolate the lowest set bit
  assign first = mask & (~mask + MASK_W'(1));
  assign rest  = mask & ~first;

  always_comb begin
    pos = '0;
    for (int i = 0; i < MASK_W; i++)
      if (first[i]) pos = pos | POS_W'(i);
  end
endmodule

// File: rtl/cmd_stream_parser.sv
module cmd_stream_parser
  import cmdp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [WORD_W-1:0]   in_data,
  output logic                in_ready,
  output logic                wr_valid,
  output logic [CLASS_W-1:0]  wr_class,
  output logic [OFF_W-1:0]    wr_offset,
  output logic [WORD_W-1:0]   wr_data,
  output logic                gather_valid,
  output logic [OFF_W-1:0]    gather_offset,
  output logic                gather_insert,
  output logic                gather_type,
  output logic [GCNT_W-1:0]   gather_count,
  output logic [WORD_W-1:0]   gather_addr,
  output logic                restart_valid,
  output logic [WORD_W-1:0]   restart_addr,
  output logic                lock_acq_valid,
  output logic                lock_rel_valid,
  output logic [LOCK_W-1:0]   lock_index,
  output logic                ext_err,
  output logic [CLASS_W-1:0]  cur_class,
  output logic                in_payload
);
  hdr_t               h;
  logic [CNT_W-1:0]   cnt_q;
  pmode_e             mode_q;
  logic [OFF_W-1:0]   off_q;
  logic [MASK_W-1:0]  mask_q;
  logic [CLASS_W-1:0] class_q;
  logic               gins_q, gtyp_q;
  logic [GCNT_W-1:0]  gcnt_q;
  logic [POS_W-1:0]   pick_pos;
  logic [MASK_W-1:0]  mask_rest;
  logic [OFF_W-1:0]   pay_off;

  // named events for the checks
  logic accept, hdr_take, pay_take;

  assign in_ready   = 1'b1;
  assign accept     = in_valid && in_ready;
  assign in_payload = (cnt_q != '0);
  assign hdr_take   = accept && !in_payload;
  assign pay_take   = accept && in_payload;
  assign cur_class  = class_q;

  cmdp_hdr_decode u_dec (.word(in_data), .hdr(h));
  cmdp_mask_pick  u_pick (.mask(mask_q), .pos(pick_pos), .rest(mask_rest));

  always_comb begin
    case (mode_q)
      PM_SCATTER: pay_off = off_add(off_q, pick_pos);
      default:    pay_off = off_q;
    endcase
  end

  // command state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      mode_q  <= PM_STEP;
      off_q   <= '0;
      mask_q  <= '0;
      class_q <= '0;
      gins_q  <= 1'b0;
      gtyp_q  <= 1'b0;
      gcnt_q  <= '0;
    end else if (hdr_take) begin
      if (h.class_we) class_q <= h.class_val;
      cnt_q  <= h.n_payload;
      mode_q <= h.mode;
      off_q  <= h.base;
      mask_q <= h.mask;
      gins_q <= h.g_insert;
      gtyp_q <= h.g_type;
      gcnt_q <= h.g_count;
    end else if (pay_take) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (mode_q == PM_STEP)    off_q  <= off_q + OFF_W'(1);
      if (mode_q == PM_SCATTER) mask_q <= mask_rest;
    end
  end

  // output strobes and their fields
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid       <= 1'b0;
      wr_class       <= '0;
      wr_offset      <= '0;
      wr_data        <= '0;
      gather_valid   <= 1'b0;
      gather_offset  <= '0;
      gather_insert  <= 1'b0;
      gather_type    <= 1'b0;
      gather_count   <= '0;
      gather_addr    <= '0;
      restart_valid  <= 1'b0;
      restart_addr   <= '0;
      lock_acq_valid <= 1'b0;
      lock_rel_valid <= 1'b0;
      lock_index     <= '0;
      ext_err        <= 1'b0;
    end else begin
      wr_valid       <= 1'b0;
      gather_valid   <= 1'b0;
      restart_valid  <= 1'b0;
      lock_acq_valid <= 1'b0;
      lock_rel_valid <= 1'b0;
      ext_err        <= 1'b0;
      if (pay_take) begin
        if (mode_q == PM_ADDR) begin
          gather_valid  <= 1'b1;
          gather_offset <= off_q;
          gather_insert <= gins_q;
          gather_type   <= gtyp_q;
          gather_count  <= gcnt_q;
          gather_addr   <= in_data;
        end else begin
          wr_valid  <= 1'b1;
          wr_class  <= class_q;
          wr_offset <= pay_off;
          wr_data   <= in_data;
        end
      end else if (hdr_take) begin
        if (h.imm_we) begin
          wr_valid  <= 1'b1;
          wr_class  <= class_q;
          wr_offset <= h.base;
          wr_data   <= WORD_W'(h.imm_data);
        end
        if (h.restart) begin
          restart_valid <= 1'b1;
          restart_addr  <= h.restart_addr;
        end
        if (h.acq || h.rel) lock_index <= h.lock_idx;
        lock_acq_valid <= h.acq;
        lock_rel_valid <= h.rel;
        ext_err        <= h.unk;
      end
    end
  end

  // R12
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_valid, gather_valid, restart_valid, lock_acq_valid, lock_rel_valid, ext_err}));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !(wr_valid || gather_valid || restart_valid || lock_acq_valid || lock_rel_valid || ext_err));

  // R11
  pay_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_take |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R6
  mask_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_payload && mode_q == PM_SCATTER) |-> ($countones(mask_q) == 32'(cnt_q)));

  // R9
  restart_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_valid |-> (restart_addr[RESTART_SH-1:0] == '0));

  // R10
  ext_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_err) |-> ($past(hdr_take) && $past(in_data[31:28]) == OP_EXTEND));

  // R8
  gather_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gather_valid |-> ($past(pay_take) && $past(mode_q) == PM_ADDR));
endmodule

// File: tb/cmd_stream_parser_tb.sv
module cmd_stream_parser_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, wr_valid, gather_valid, gather_insert, gather_type;
  logic        restart_valid, lock_acq_valid, lock_rel_valid, ext_err, in_payload;
  logic [9:0]  wr_class, cur_class;
  logic [11:0] wr_offset, gather_offset;
  logic [31:0] wr_data, gather_addr, restart_addr;
  logic [13:0] gather_count;
  logic [7:0]  lock_index;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_stream_parser dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .wr_valid(wr_valid), .wr_class(wr_class), .wr_offset(wr_offset), .wr_data(wr_data),
    .gather_valid(gather_valid), .gather_offset(gather_offset), .gather_insert(gather_insert),
    .gather_type(gather_type), .gather_count(gather_count), .gather_addr(gather_addr),
    .restart_valid(restart_valid), .restart_addr(restart_addr),
    .lock_acq_valid(lock_acq_valid), .lock_rel_valid(lock_rel_valid), .lock_index(lock_index),
    .ext_err(ext_err), .cur_class(cur_class), .in_payload(in_payload));

  // bench model state
  logic [9:0]  m_class = '0;
  int          m_left = 0;
  int          m_mode = 0;   // 0 step, 1 hold, 2 scatter, 3 address
  logic [11:0] m_base = '0;
  logic [15:0] m_mask = '0;
  int          m_idx = 0;
  logic        m_gi = 0, m_gt = 0;
  logic [13:0] m_gc = '0;
  string       m_tag = "R2";

  // expected outputs
  logic        e_wr, e_g, e_rs, e_acq, e_rel, e_err;
  logic [9:0]  e_wcls;
  logic [11:0] e_woff, e_goff;
  logic [31:0] e_wdat, e_gaddr, e_raddr;
  logic [13:0] e_gc;
  logic        e_gi, e_gt;
  logic [7:0]  e_idx;

  function automatic int ones(input logic [15:0] m);
    int n = 0;
    for (int i = 0; i < 16; i++) if (m[i]) n++;
    return n;
  endfunction

  // bit position of the n-th set bit (n from 0), scanning upward
  function automatic int nth_pos(input logic [15:0] m, input int n);
    int seen = 0;
    for (int i = 0; i < 16; i++)
      if (m[i]) begin
        if (seen == n) return i;
        seen++;
      end
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] w, output string tag);
    {e_wr, e_g, e_rs, e_acq, e_rel, e_err} = '0;
    if (m_left > 0) begin
      tag = m_tag;
      if (m_mode == 3) begin
        e_g = 1; e_goff = m_base; e_gi = m_gi; e_gt = m_gt; e_gc = m_gc; e_gaddr = w;
      end else begin
        e_wr = 1; e_wcls = m_class; e_wdat = w;
        if (m_mode == 0)      e_woff = m_base + 12'(m_idx);
        else if (m_mode == 1) e_woff = m_base;
        else                  e_woff = m_base + 12'(nth_pos(m_mask, m_idx));
      end
      m_idx++; m_left--;
    end else begin
      m_idx = 0; m_left = 0; m_base = w[27:16];
      case (w[31:28])
        4'd0: begin
          m_class = w[15:6]; m_mask = {10'd0, w[5:0]};
          m_left = ones(m_mask); m_mode = 2; m_tag = "R3";
        end
        4'd1: begin m_left = int'(w[15:0]); m_mode = 0; m_tag = "R4"; end
        4'd2: begin m_left = int'(w[15:0]); m_mode = 1; m_tag = "R5"; end
        4'd3: begin m_mask = w[15:0]; m_left = ones(m_mask); m_mode = 2; m_tag = "R6"; end
        4'd4: begin
          m_tag = "R7"; e_wr = 1; e_wcls = m_class; e_woff = w[27:16]; e_wdat = {16'd0, w[15:0]};
        end
        4'd5: begin m_tag = "R9"; e_rs = 1; e_raddr = {w[27:0], 4'd0}; end
        4'd6: begin
          m_tag = "R8"; m_left = 1; m_mode = 3; m_gi = w[15]; m_gt = w[14]; m_gc = w[13:0];
        end
        4'd14: begin
          m_tag = "R10"; e_idx = w[7:0];
          if (w[27:24] == 4'd0) e_acq = 1;
          else if (w[27:24] == 4'd1) e_rel = 1;
          else e_err = 1;
        end
        default: m_tag = "R2";
      endcase
      tag = m_tag;
    end
  endtask

  task automatic compare(input string req);
    chk(wr_valid == e_wr, req, "wr_valid", 32'(wr_valid), 32'(e_wr));
    if (e_wr && wr_valid) begin
      chk(wr_class == e_wcls, req, "wr_class", 32'(wr_class), 32'(e_wcls));
      chk(wr_offset == e_woff, req, "wr_offset", 32'(wr_offset), 32'(e_woff));
      chk(wr_data == e_wdat, req, "wr_data", wr_data, e_wdat);
    end
    chk(gather_valid == e_g, req, "gather_valid", 32'(gather_valid), 32'(e_g));
    if (e_g && gather_valid)
      chk({gather_offset, gather_insert, gather_type, gather_count} == {e_goff, e_gi, e_gt, e_gc}
          && gather_addr == e_gaddr, req, "gather fields",
          {4'd0, gather_offset, gather_insert, gather_type, gather_count},
          {4'd0, e_goff, e_gi, e_gt, e_gc});
    chk(restart_valid == e_rs, req, "restart_valid", 32'(restart_valid), 32'(e_rs));
    if (e_rs && restart_valid) chk(restart_addr == e_raddr, req, "restart_addr", restart_addr, e_raddr);
    chk(lock_acq_valid == e_acq, req, "lock_acq", 32'(lock_acq_valid), 32'(e_acq));
    chk(lock_rel_valid == e_rel, req, "lock_rel", 32'(lock_rel_valid), 32'(e_rel));
    if (e_acq || e_rel) chk(lock_index == e_idx, req, "lock_index", 32'(lock_index), 32'(e_idx));
    chk(ext_err == e_err, req, "ext_err", 32'(ext_err), 32'(e_err));
    chk(cur_class == m_class, req, "cur_class", 32'(cur_class), 32'(m_class));
    chk(in_payload == (m_left > 0), req, "in_payload", 32'(in_payload), 32'(m_left > 0));
  endtask

  task automatic send(input logic [31:0] w, input string force_tag);
    string tag;
    model(w, tag);
    if (force_tag != "") tag = force_tag;
    in_valid = 1'b1; in_data = w;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    compare(tag);
  endtask

  task automatic idle();
    in_data = $urandom;
    in_valid = 1'b0;
    {e_wr, e_g, e_rs, e_acq, e_rel, e_err} = '0;
    @(posedge clk);
    @(negedge clk);
    compare("R12");
  endtask

  task automatic finish_payload(input string t);
    while (m_left > 0) send($urandom, t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    {e_wr, e_g, e_rs, e_acq, e_rel, e_err} = '0;
    compare("R1");
    chk(in_ready == 1'b1, "R1", "in_ready", 32'(in_ready), 32'd1);

    // directed corner cases
    send(32'h0000_0000 | (32'h2A5 << 6), "R3");          // zero-mask set-class
    send(32'h0100_0000 | (32'h155 << 6) | 32'h29, "R3"); // class 0x155, mask 101001
    finish_payload("R3");
    send(32'h1FFE_0004, "R4");                          // wraps past 0xFFF
    finish_payload("R4");
    send(32'h1123_0000, "R4");                          // count 0
    send(32'h2045_0003, "R5");
    finish_payload("R5");
    send(32'h3010_8001, "R6");
    finish_payload("R6");
    send(32'h4ABC_BEEF, "R7");
    send(32'h5FFF_FFFF, "R9");
    send(32'h6777_C005, "R8");
    send(32'hDEAD_0000, "R8");
    send(32'hE000_0012, "R10");
    send(32'hE100_00FE, "R10");
    send(32'hE700_0033, "R10");
    send(32'hF123_4567, "R2");
    send(32'h7000_0001, "R2");
    send(32'h1000_0002, "R11");
    send(32'h5000_0001, "R11");                         // looks like restart, is payload
    send(32'hE700_0000, "R11");                         // looks like extend, is payload
    idle();
    idle();

    // constrained random streams
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      logic [3:0]  op;
      w = $urandom;
      case ($urandom_range(0, 9))
        0: op = 4'd0;  1: op = 4'd1;  2: op = 4'd2;  3: op = 4'd3;
        4: op = 4'd4;  5: op = 4'd5;  6: op = 4'd6;  7: op = 4'd14;
        8: op = 4'(7 + $urandom_range(0, 6));
        default: op = 4'd15;
      endcase
      w[31:28] = op;
      if (op == 4'd1 || op == 4'd2) w[15:0] = 16'($urandom_range(0, 5));
      if (op == 4'd14) w[27:24] = 4'($urandom_range(0, 3));
      send(w, "");
      while (m_left > 0) begin
        if ($urandom_range(0, 4) == 0) idle();
        send($urandom, "");
      end
      if ($urandom_range(0, 5) == 0) idle();
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule